// File: doc/BRIEF.md
# Indexed infoframe packet buffer

This block keeps a set of auxiliary data packets, such as the video and audio infoframes, in on-chip storage. It sends them out as a byte stream once per video frame. Software selects a packet slot through an index register. It then reads or writes that slot's three header bytes and 28 payload bytes through a 31-byte window in the register space. A per-slot auto-send mask decides which slots go out after each rising edge of vertical sync. A manual request sends the indexed slot once.

The hardware can fill payload byte 0 with a checksum taken over the header and the payload bytes that the length field covers, so software may leave that byte at zero. Each packet is copied into a transmit shadow when its transmission starts. A register write to a slot that is being sent therefore changes only later transmissions. The stream carries a valid/ready handshake with start and end markers. Island coding, error-correction coding and serialization belong to the next stage.

Register map, 6-bit address: 0x00 slot index; 0x01 control (bit 0 manual send request, which reads back as busy; bit 1 automatic checksum enable); 0x04 and 0x05 auto-send mask for slots 0..7 and 8..15; 0x20..0x3E window, where offset 0x20+k is packet byte k.

Top module: `pkt_infoframe_buf`

## Requirements
- R1: After reset the stream is idle (pkt_valid low), the index, control and mask registers read 0x00, and every stored packet byte reads 0x00.
- R2: A write to address 0x20+k (k = 0..30) stores byte k of the slot chosen by the index register. A read of the same address returns it, and the other slots keep their contents.
- R3: Each packet is 31 bytes on the stream in the order header bytes 0..2 and then payload bytes 0..27. pkt_sop is high only on the first byte and pkt_eop only on the last. At least one idle cycle follows every packet.
- R4: On a rising edge of vsync, every slot whose bit is set in the auto-send mask (bit n = slot n) is sent once, in ascending slot order. Slots whose bit is clear are not sent.
- R5: With control bit 1 set, payload byte 0 on the stream equals 256 minus the modulo-256 sum of header bytes 0..2 and payload bytes 1..L, where L is header byte 2 limited to 27. The stored payload byte 0 is ignored. With bit 1 clear, the stored byte goes out unchanged.
- R6: While pkt_ready is low, pkt_valid stays high and the data and markers hold their values.
- R7: Writing control bit 0 as 1 sends the indexed slot once. Control bit 0 reads 1 until the last byte of that packet is accepted and 0 afterwards.
- R8: A window write to a slot during its transmission leaves the packet in flight unchanged and appears in the next transmission of that slot.
- R9: vsync held high starts only one round of auto-send. A new round needs vsync to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| vsync | input | 1 | Vertical sync, synchronous to clk |
| pkt_ready | input | 1 | Stream consumer ready |
| pkt_valid | output | 1 | Stream byte valid |
| pkt_data | output | 8 | Stream byte |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |

## Verification
The hardest case to reach is a write to a slot while that same slot is in flight. From the ports, the window of a packet lasts only 32 cycles. The bench holds pkt_ready low after a manual request, so the packet stays parked on its first byte. It then rewrites a header byte of that slot through the window, releases ready, and checks both the packet in flight and a second transmission against the old and new checksums.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  localparam int HDR_BYTES = 3;
  localparam int PAY_BYTES = 28;
  localparam int PKT_BYTES = HDR_BYTES + PAY_BYTES;
  localparam int PKT_BITS  = PKT_BYTES * 8;
  localparam int BYTE_W    = 5;
  localparam int ADDR_W    = 6;
  localparam int CK_POS    = HDR_BYTES;          // payload byte 0
  localparam int MAX_LEN   = PAY_BYTES - 1;

  localparam logic [ADDR_W-1:0] A_INDEX = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h01;
  localparam logic [ADDR_W-1:0] A_MASK0 = 6'h04;

  typedef logic [7:0]          byte_t;
  typedef logic [PKT_BITS-1:0] pkt_t;

  // Byte that makes header + covered payload + checksum sum to zero.
  function automatic byte_t pkt_checksum(input pkt_t pk);
    int    last;
    byte_t acc;
    last = int'(pk[23:16]);
    if (last > MAX_LEN) last = MAX_LEN;
    acc = pk[7:0] + pk[15:8] + pk[23:16];
    for (int i = 1; i < PAY_BYTES; i++) begin
      if (i <= last) acc = acc + pk[(HDR_BYTES + i) * 8 +: 8];
    end
    return 8'd0 - acc;
  endfunction

  function automatic pkt_t pkt_patch(input pkt_t pk);
    pkt_t r;
    r = pk;
    r[CK_POS * 8 +: 8] = pkt_checksum(pk);
    return r;
  endfunction
endpackage

// File: rtl/pkt_ctrl_regs.sv
module pkt_ctrl_regs
  import pktbuf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int IDX_W      = $clog2(NUM_SLOTS),
  parameter int MASK_BYTES = (NUM_SLOTS + 7) / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [IDX_W-1:0]        idx,
  output logic [MASK_BYTES*8-1:0] mask_raw,
  output logic                    cksum_en,
  output logic                    man_req,
  output logic                    win_we,
  output logic [BYTE_W-1:0]       win_byte
);
  logic [IDX_W-1:0] idx_q;
  logic             ck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ck_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_INDEX) idx_q <= wdata[IDX_W-1:0];
      if (addr == A_CTRL)  ck_q  <= wdata[1];
    end
  end

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
    localparam logic [ADDR_W-1:0] MA = A_MASK0 + ADDR_W'(b);
    always_ff @(posedge clk) begin
      if (!rst_n)                     mask_raw[b*8 +: 8] <= '0;
      else if (wr_en && addr == MA)   mask_raw[b*8 +: 8] <= wdata;
    end
  end

  assign idx      = idx_q;
  assign cksum_en = ck_q;
  assign man_req  = wr_en && (addr == A_CTRL) && wdata[0];
  assign win_byte = addr[BYTE_W-1:0];
  assign win_we   = wr_en && addr[ADDR_W-1] && (addr[BYTE_W-1:0] != BYTE_W'(PKT_BYTES));
endmodule

// File: rtl/pkt_slot_store.sv
module pkt_slot_store
  import pktbuf_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wslot,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [7:0]        wdata,
  input  logic [IDX_W-1:0]  rslot,
  input  logic [BYTE_W-1:0] rbyte,
  output logic [7:0]        rdata,
  input  logic [IDX_W-1:0]  tslot,
  output pkt_t              tbits
);
  pkt_t mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) mem[s] <= '0;
    end else if (we) begin
      mem[wslot][wbyte*8 +: 8] <= wdata;
    end
  end

  assign rdata = (rbyte < BYTE_W'(PKT_BYTES)) ? mem[rslot][rbyte*8 +: 8] : 8'h00;
  assign tbits = mem[tslot];
endmodule

// File: rtl/pkt_send_sched.sv
module pkt_send_sched #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic [NUM_SLOTS-1:0] auto_mask,
  input  logic                 man_req,
  input  logic [IDX_W-1:0]     man_slot,
  input  logic                 tx_idle,
  input  logic                 tx_done,
  input  logic [IDX_W-1:0]     tx_slot,
  output logic                 start,
  output logic [IDX_W-1:0]     start_slot,
  output logic                 man_busy
);
  logic [NUM_SLOTS-1:0] pend_q, pend_d;
  logic                 vs_q, vs_rise, found;
  logic [IDX_W-1:0]     pick, mslot_q;
  logic                 busy_q;

  // lowest pending slot wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign vs_rise    = vsync && !vs_q;
  assign start      = found && tx_idle;
  assign start_slot = pick;

  always_comb begin
    pend_d = pend_q;
    if (start)   pend_d[pick] = 1'b0;
    if (vs_rise) pend_d = pend_d | auto_mask;
    if (man_req) pend_d[man_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      vs_q    <= 1'b0;
      busy_q  <= 1'b0;
      mslot_q <= '0;
    end else begin
      pend_q <= pend_d;
      vs_q   <= vsync;
      if (man_req) begin
        busy_q  <= 1'b1;
        mslot_q <= man_slot;
      end else if (tx_done && tx_slot == mslot_q && !pend_q[mslot_q]) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign man_busy = busy_q;

  // R4: a vsync rise with a non-empty mask leaves work pending
  a_r4_vsync_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) && (auto_mask != '0)) |=> (pend_q != '0));

  // R7: busy only drops right after the transmitter finished a packet
  a_r7_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tx_done));
endmodule

// File: rtl/pkt_stream_tx.sv
module pkt_stream_tx
  import pktbuf_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_slot,
  input  pkt_t             slot_bits,
  input  logic             cksum_en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             tx_idle,
  output logic             tx_done,
  output logic [IDX_W-1:0] tx_slot
);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(PKT_BYTES - 1);

  pkt_t              shadow_q;
  logic [BYTE_W-1:0] cnt_q;
  logic              busy_q;
  logic [IDX_W-1:0]  slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      slot_q   <= '0;
    end else if (start) begin
      shadow_q <= cksum_en ? pkt_patch(slot_bits) : slot_bits;
      cnt_q    <= '0;
      busy_q   <= 1'b1;
      slot_q   <= start_slot;
    end else if (busy_q && out_ready) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign out_valid = busy_q;
  assign out_data  = shadow_q[cnt_q*8 +: 8];
  assign out_sop   = busy_q && (cnt_q == '0);
  assign out_eop   = busy_q && (cnt_q == LAST);
  assign tx_idle   = !busy_q;
  assign tx_done   = busy_q && out_ready && (cnt_q == LAST);
  assign tx_slot   = slot_q;

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  a_r3_first_is_sop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);

  a_r3_gap_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> !out_valid);
endmodule

// File: rtl/pkt_infoframe_buf.sv
module pkt_infoframe_buf
  import pktbuf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int IDX_W      = $clog2(NUM_SLOTS),
  parameter int MASK_BYTES = (NUM_SLOTS + 7) / 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       vsync,
  input  logic       pkt_ready,
  output logic       pkt_valid,
  output logic [7:0] pkt_data,
  output logic       pkt_sop,
  output logic       pkt_eop
);
  logic [IDX_W-1:0]        idx, start_slot, tx_slot;
  logic [MASK_BYTES*8-1:0] mask_raw;
  logic                    cksum_en, man_req, win_we, man_busy;
  logic [BYTE_W-1:0]       win_byte;
  logic [7:0]              win_rd;
  logic                    start, tx_idle, tx_done;
  pkt_t                    tbits;

  pkt_ctrl_regs #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .MASK_BYTES(MASK_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .idx(idx), .mask_raw(mask_raw), .cksum_en(cksum_en), .man_req(man_req),
    .win_we(win_we), .win_byte(win_byte));

  pkt_slot_store #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(win_we), .wslot(idx), .wbyte(win_byte),
    .wdata(reg_wdata), .rslot(idx), .rbyte(reg_addr[BYTE_W-1:0]), .rdata(win_rd),
    .tslot(start_slot), .tbits(tbits));

  pkt_send_sched #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .auto_mask(mask_raw[NUM_SLOTS-1:0]),
    .man_req(man_req), .man_slot(idx), .tx_idle(tx_idle), .tx_done(tx_done),
    .tx_slot(tx_slot), .start(start), .start_slot(start_slot), .man_busy(man_busy));

  pkt_stream_tx #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .start_slot(start_slot),
    .slot_bits(tbits), .cksum_en(cksum_en), .out_ready(pkt_ready),
    .out_valid(pkt_valid), .out_data(pkt_data), .out_sop(pkt_sop), .out_eop(pkt_eop),
    .tx_idle(tx_idle), .tx_done(tx_done), .tx_slot(tx_slot));

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_INDEX)      reg_rdata = 8'(idx);
    else if (reg_addr == A_CTRL)  reg_rdata = {6'b0, cksum_en, man_busy};
    else if (reg_addr[5])         reg_rdata = win_rd;
    else begin
      for (int b = 0; b < MASK_BYTES; b++) begin
        if (reg_addr == A_MASK0 + 6'(b)) reg_rdata = mask_raw[b*8 +: 8];
      end
    end
  end
endmodule

// File: tb/pkt_infoframe_buf_tb.sv
module pkt_infoframe_buf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       vsync = 1'b0;
  logic       pkt_ready = 1'b1;
  logic       pkt_valid, pkt_sop, pkt_eop;
  logic [7:0] pkt_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pkt_infoframe_buf dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vsync(vsync),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop));

  // captured stream
  logic [7:0] cap_d [1024];
  logic       cap_s [1024];
  logic       cap_e [1024];
  int         cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready && cap_n < 1024) begin
      cap_d[cap_n] = pkt_data;
      cap_s[cap_n] = pkt_sop;
      cap_e[cap_n] = pkt_eop;
      cap_n = cap_n + 1;
    end
  end

  logic [7:0] model [16][31];

  // slot, ck, hb0, hb1, len, seed
  localparam logic [36:0] VEC [6] = '{
    {1'b1, 4'd6,  8'h82, 8'h02, 8'h0D, 8'h10},
    {1'b1, 4'd8,  8'h84, 8'h01, 8'h0A, 8'h33},
    {1'b1, 4'd0,  8'h00, 8'h00, 8'h00, 8'h5A},
    {1'b1, 4'd15, 8'hAA, 8'hBB, 8'h1B, 8'hC4},
    {1'b1, 4'd3,  8'h11, 8'h22, 8'hC8, 8'hE1},
    {1'b0, 4'd5,  8'h82, 8'h02, 8'h0D, 8'h77}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fill(input int slot, input logic [7:0] h0, input logic [7:0] h1,
                      input logic [7:0] len, input logic [7:0] seed);
    wr(6'h00, 8'(slot));
    for (int i = 0; i < 31; i++) begin
      logic [7:0] b;
      b = (i == 0) ? h0 : (i == 1) ? h1 : (i == 2) ? len : 8'(seed + 8'(7 * i));
      wr(6'h20 + 6'(i), b);
      model[slot][i] = b;
    end
  endtask

  // expected byte: total of every counted byte must vanish modulo 256
  function automatic logic [7:0] exp_b(input int slot, input int i, input bit ck);
    int n;
    logic [7:0] s;
    if (!(ck && i == 3)) return model[slot][i];
    n = int'(model[slot][2]);
    if (n > 27) n = 27;
    s = 8'h00;
    for (int k = 0; k < 31; k++) begin
      if (k < 3 || (k > 3 && (k - 3) <= n)) s = s + model[slot][k];
    end
    return 8'h00 - s;
  endfunction

  task automatic wait_bytes(input int n);
    int t;
    t = 0;
    while (cap_n < n && t < 3000) begin
      @(posedge clk);
      t++;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic check_pkt(input int base, input int slot, input bit ck, input string tag);
    for (int i = 0; i < 31; i++) begin
      check(cap_d[base + i] == exp_b(slot, i, ck), tag, cap_d[base + i], exp_b(slot, i, ck));
      check(cap_s[base + i] == (i == 0), {tag, " sop"}, cap_s[base + i], (i == 0));
      check(cap_e[base + i] == (i == 30), {tag, " eop"}, cap_e[base + i], (i == 30));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] old_b [31];
    int base;
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 31; i++) model[s][i] = 8'h00;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pkt_valid == 1'b0, "R1 valid", pkt_valid, 0);
    rd(6'h00, r); check(r == 8'h00, "R1 index", r, 0);
    rd(6'h01, r); check(r == 8'h00, "R1 ctrl", r, 0);
    rd(6'h04, r); check(r == 8'h00, "R1 mask0", r, 0);
    rd(6'h05, r); check(r == 8'h00, "R1 mask1", r, 0);
    rd(6'h25, r); check(r == 8'h00, "R1 byte", r, 0);

    // R2 window write/read, other slots untouched
    fill(6, 8'h82, 8'h02, 8'h0D, 8'h01);
    rd(6'h20, r); check(r == 8'h82, "R2 slot6 hb0", r, 8'h82);
    rd(6'h3E, r); check(r == model[6][30], "R2 slot6 pb27", r, model[6][30]);
    wr(6'h00, 8'd8);
    rd(6'h20, r); check(r == 8'h00, "R2 slot8 untouched", r, 0);
    rd(6'h00, r); check(r == 8'h08, "R2 index readback", r, 8);

    // vector table: R3, R5, R7 via manual sends
    for (int v = 0; v < 6; v++) begin
      logic ck;
      int sl;
      ck = VEC[v][36];
      sl = int'(VEC[v][35:32]);
      fill(sl, VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      base = cap_n;
      wr(6'h01, {6'b0, ck, 1'b1});
      wait_bytes(base + 31);
      check(cap_n - base == 31, "R7 one packet", cap_n - base, 31);
      check_pkt(base, sl, ck, ck ? "R5 R3 vec" : "R5 raw pb0 vec");
      rd(6'h01, r); check(r[0] == 1'b0, "R7 busy cleared", r[0], 0);
    end

    // R4 auto-send in ascending order: slots 8, 6, 3 enabled
    wr(6'h01, 8'h02);
    wr(6'h04, 8'h48);
    wr(6'h05, 8'h01);
    base = cap_n;
    @(posedge clk); #1 vsync = 1'b1;
    repeat (2) @(posedge clk); #1 vsync = 1'b0;
    wait_bytes(base + 93);
    repeat (40) @(posedge clk);
    check(cap_n - base == 93, "R4 count", cap_n - base, 93);
    check_pkt(base, 3, 1'b1, "R4 first slot3");
    check_pkt(base + 31, 6, 1'b1, "R4 second slot6");
    check_pkt(base + 62, 8, 1'b1, "R4 third slot8");

    // R9 vsync held high: single round
    wr(6'h04, 8'h40);
    wr(6'h05, 8'h00);
    base = cap_n;
    @(posedge clk); #1 vsync = 1'b1;
    repeat (300) @(posedge clk);
    check(cap_n - base == 31, "R9 held high", cap_n - base, 31);
    #1 vsync = 1'b0;
    repeat (50) @(posedge clk);
    check(cap_n - base == 31, "R9 after fall", cap_n - base, 31);
    #1 vsync = 1'b1;
    repeat (60) @(posedge clk);
    #1 vsync = 1'b0;
    check(cap_n - base == 62, "R9 new rise", cap_n - base, 62);
    wr(6'h04, 8'h00);

    // R6 stall + R7 busy + R8 write during send
    wr(6'h00, 8'd6);
    @(posedge clk); #1 pkt_ready = 1'b0;
    base = cap_n;
    wr(6'h01, 8'h03);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pkt_valid && pkt_sop && pkt_data == 8'h82, "R6 parked", pkt_data, 8'h82);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pkt_valid && pkt_sop && pkt_data == 8'h82, "R6 held", pkt_data, 8'h82);
    rd(6'h01, r); check(r == 8'h03, "R7 busy while stalled", r, 8'h03);
    for (int i = 0; i < 31; i++) old_b[i] = exp_b(6, i, 1'b1);
    wr(6'h21, 8'h55);
    model[6][1] = 8'h55;
    @(posedge clk); #1 pkt_ready = 1'b1;
    wait_bytes(base + 31);
    for (int i = 0; i < 31; i++)
      check(cap_d[base + i] == old_b[i], "R8 in-flight unchanged", cap_d[base + i], old_b[i]);
    base = cap_n;
    wr(6'h01, 8'h03);
    wait_bytes(base + 31);
    check_pkt(base, 6, 1'b1, "R8 next send updated");
    check(cap_d[base + 1] == 8'h55, "R8 new hb1", cap_d[base + 1], 8'h55);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule